// File: doc/BRIEF.md
# Dual-Clock Bus-Matching FIFO

This block is a first-in first-out buffer whose write and read sides each run on their own clock. The two clocks may be unrelated or may be the same clock. Each side has a width strap that is sampled while reset is held low. With the strap low, that side moves full 18-bit words. With the strap high, it moves 9-bit halves on the low bits of its bus. A 9-bit producer can therefore feed an 18-bit consumer, and the reverse also works. The array always holds 18-bit words. On the write side, two halves are packed with the earlier half in bits 8:0. On the read side, a stored word is unpacked in the same order.

Enables and status flags are active low. Full, half-full and almost-full are decided in the write clock domain. Empty and almost-empty are decided in the read clock domain. Each side sees the other side's pointer only as Gray code passed through a two-stage synchroniser. Two offset registers set the almost thresholds. The almost-full offset has a write port on the write clock, and the almost-empty offset has a write port on the read clock. Reset loads both offsets with a default of 7 words.

Top module: `bmf_fifo`

## Requirements
- R1: With iw_sel_i high during reset, the write side is 9 bits wide and bits 17:9 of d_i are ignored. The first accepted half lands in bits 8:0 of a stored word and the second in bits 17:9. A lone half is not visible to the reader.
- R2: With ow_sel_i high during reset, the read side is 9 bits wide. Each stored word is delivered bits 8:0 first, then bits 17:9, on q_o[8:0], with q_o[17:9] zero. With ow_sel_i low, q_o carries the whole 18-bit word.
- R3: An active-low rst_ni returns both pointers to the first location, clears q_o to zero and reloads both offsets with 7.
- R4: Directly after reset, ff_n_o, hf_n_o and paf_n_o are 1, and ef_n_o and pae_n_o are 0.
- R5: On a wclk_i edge with wen_ni low and the FIFO not full, a word is accepted. ff_n_o is 0 once DEPTH words are held, and writes are then ignored.
- R6: After a read frees space in a full FIFO, ff_n_o returns to 1 within a few write clocks.
- R7: On an rclk_i edge with ren_ni low and data available, q_o loads the next item in arrival order. At all other times q_o holds its value, including when a read is attempted on an empty FIFO.
- R8: ef_n_o is 0 when the read side has nothing to deliver. It is 1 once a stored word has crossed to the read domain, or while an unpacked high half is still pending.
- R9: hf_n_o is 0 when the write-side count of stored words is greater than DEPTH/2.
- R10: paf_n_o is 0 when the write-side count is at least DEPTH minus the almost-full offset. It is updated on wclk_i.
- R11: pae_n_o is 0 when the read-side count is at most the almost-empty offset. It is updated on rclk_i.
- R12: af_off_we_i loads af_off_i into the almost-full offset on wclk_i. ae_off_we_i loads ae_off_i into the almost-empty offset on rclk_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iw_sel_i | input | 1 | Write width strap: 0 selects 18 bits, 1 selects 9 bits |
| ow_sel_i | input | 1 | Read width strap: 0 selects 18 bits, 1 selects 9 bits |
| wen_ni | input | 1 | Write enable, active low |
| d_i | input | 18 | Write data |
| ren_ni | input | 1 | Read enable, active low |
| q_o | output | 18 | Read data register |
| ff_n_o | output | 1 | Full, active low |
| ef_n_o | output | 1 | Empty, active low |
| hf_n_o | output | 1 | Half-full, active low |
| paf_n_o | output | 1 | Almost-full, active low |
| pae_n_o | output | 1 | Almost-empty, active low |
| af_off_we_i | input | 1 | Almost-full offset load strobe (write clock) |
| af_off_i | input | AW | Almost-full offset value |
| ae_off_we_i | input | 1 | Almost-empty offset load strobe (read clock) |
| ae_off_i | input | AW | Almost-empty offset value |

## Verification
The assertions assume that the width straps stay steady for as long as reset is low. They also assume that the offset values are smaller than DEPTH, so that a full FIFO is always almost full and an empty one is always almost empty. Each property looks at only one clock domain, so no property depends on the phase between the clocks. The stimulus sets the straps before reset is applied and changes them only inside a new reset. Every input is driven on the falling edge of its own clock. The offsets written are small values.

// File: rtl/bmf_pkg.sv
package bmf_pkg;
  localparam int HALF_W = 9;
  localparam int WORD_W = 2 * HALF_W;

  typedef enum logic {
    PW_WORD = 1'b0,
    PW_HALF = 1'b1
  } port_width_e;
endpackage

// File: rtl/bmf_gray_sync.sv
module bmf_gray_sync #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  // gray to binary: each bit is the xor of all bits at or above it
  for (genvar i = 0; i < W; i++) begin : g_bin
    assign bin_o[i] = ^s2_q[W-1:i];
  end
endmodule

// File: rtl/bmf_dpram.sv
module bmf_dpram #(
  parameter int DEPTH = 64,
  parameter int W     = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/bmf_wr_ctl.sv
module bmf_wr_ctl
  import bmf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DEF_OFF = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              iw_sel_i,
  input  logic              wen_ni,
  input  logic [WORD_W-1:0] d_i,
  input  logic [PW-1:0]     rgray_i,
  input  logic              af_off_we_i,
  input  logic [AW-1:0]     af_off_i,
  output logic              mem_we_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic [PW-1:0]     wgray_o,
  output logic              ff_n_o,
  output logic              hf_n_o,
  output logic              paf_n_o
);
  localparam logic [PW-1:0] FULL_LVL = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_LVL = PW'(DEPTH / 2);

  port_width_e       mode_q;
  logic              phase_q;
  logic [HALF_W-1:0] hold_q;
  logic [PW-1:0]     wptr_q, wgray_q, wptr_nxt, rptr_w, wcount;
  logic [AW-1:0]     af_off_q;
  logic              full, accept, commit;

  bmf_gray_sync #(.W(PW)) u_rsync (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .gray_i(rgray_i),
    .bin_o (rptr_w)
  );

  assign wcount   = wptr_q - rptr_w;
  assign full     = (wcount == FULL_LVL);
  assign accept   = !wen_ni && !full;
  // half mode only reaches the array on the second half
  assign commit   = accept && ((mode_q == PW_WORD) || phase_q);
  assign wptr_nxt = wptr_q + PW'(commit);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= port_width_e'(iw_sel_i);
      phase_q  <= 1'b0;
      hold_q   <= '0;
      wptr_q   <= '0;
      wgray_q  <= '0;
      af_off_q <= AW'(DEF_OFF);
    end else begin
      wptr_q  <= wptr_nxt;
      wgray_q <= wptr_nxt ^ (wptr_nxt >> 1);
      if (accept && (mode_q == PW_HALF)) begin
        phase_q <= !phase_q;
        if (!phase_q) hold_q <= d_i[HALF_W-1:0];
      end
      if (af_off_we_i) af_off_q <= af_off_i;
    end
  end

  assign mem_we_o    = commit;
  assign mem_addr_o  = wptr_q[AW-1:0];
  assign mem_wdata_o = (mode_q == PW_WORD) ? d_i : {d_i[HALF_W-1:0], hold_q};
  assign wgray_o     = wgray_q;

  assign ff_n_o  = !full;
  assign hf_n_o  = !(wcount > HALF_LVL);
  assign paf_n_o = !(({1'b0, wcount} + (PW+1)'(af_off_q)) >= (PW+1)'(DEPTH));
endmodule

// File: rtl/bmf_rd_ctl.sv
module bmf_rd_ctl
  import bmf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DEF_OFF = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              ow_sel_i,
  input  logic              ren_ni,
  input  logic [PW-1:0]     wgray_i,
  input  logic [WORD_W-1:0] mem_rdata_i,
  input  logic              ae_off_we_i,
  input  logic [AW-1:0]     ae_off_i,
  output logic [AW-1:0]     mem_addr_o,
  output logic [PW-1:0]     rgray_o,
  output logic [WORD_W-1:0] q_o,
  output logic              ef_n_o,
  output logic              pae_n_o
);
  port_width_e       mode_q;
  logic              phase_q;
  logic [HALF_W-1:0] hold_q;
  logic [PW-1:0]     rptr_q, rgray_q, rptr_nxt, wptr_r, rcount;
  logic [AW-1:0]     ae_off_q;
  logic [WORD_W-1:0] q_q;
  logic              arr_empty, avail, accept, pop;

  bmf_gray_sync #(.W(PW)) u_wsync (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .gray_i(wgray_i),
    .bin_o (wptr_r)
  );

  assign rcount    = wptr_r - rptr_q;
  assign arr_empty = (rcount == '0);
  // a pending high half keeps the port non-empty
  assign avail     = !arr_empty || ((mode_q == PW_HALF) && phase_q);
  assign accept    = !ren_ni && avail;
  assign pop       = accept && ((mode_q == PW_WORD) || !phase_q);
  assign rptr_nxt  = rptr_q + PW'(pop);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= port_width_e'(ow_sel_i);
      phase_q  <= 1'b0;
      hold_q   <= '0;
      rptr_q   <= '0;
      rgray_q  <= '0;
      q_q      <= '0;
      ae_off_q <= AW'(DEF_OFF);
    end else begin
      rptr_q  <= rptr_nxt;
      rgray_q <= rptr_nxt ^ (rptr_nxt >> 1);
      if (accept) begin
        if (mode_q == PW_WORD) begin
          q_q <= mem_rdata_i;
        end else if (!phase_q) begin
          q_q     <= {{HALF_W{1'b0}}, mem_rdata_i[HALF_W-1:0]};
          hold_q  <= mem_rdata_i[WORD_W-1:HALF_W];
          phase_q <= 1'b1;
        end else begin
          q_q     <= {{HALF_W{1'b0}}, hold_q};
          phase_q <= 1'b0;
        end
      end
      if (ae_off_we_i) ae_off_q <= ae_off_i;
    end
  end

  assign mem_addr_o = rptr_q[AW-1:0];
  assign rgray_o    = rgray_q;
  assign q_o        = q_q;
  assign ef_n_o     = avail;
  assign pae_n_o    = !(rcount <= PW'(ae_off_q));
endmodule

// File: rtl/bmf_fifo.sv
module bmf_fifo
  import bmf_pkg::*;
#(
  parameter int DEPTH   = 64,
  parameter int DEF_OFF = 7,
  localparam int AW     = $clog2(DEPTH),
  localparam int PW     = AW + 1
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              iw_sel_i,
  input  logic              ow_sel_i,
  input  logic              wen_ni,
  input  logic [WORD_W-1:0] d_i,
  input  logic              ren_ni,
  output logic [WORD_W-1:0] q_o,
  output logic              ff_n_o,
  output logic              ef_n_o,
  output logic              hf_n_o,
  output logic              paf_n_o,
  output logic              pae_n_o,
  input  logic              af_off_we_i,
  input  logic [AW-1:0]     af_off_i,
  input  logic              ae_off_we_i,
  input  logic [AW-1:0]     ae_off_i
);
  logic              mem_we;
  logic [AW-1:0]     waddr, raddr;
  logic [WORD_W-1:0] wdata, rdata;
  logic [PW-1:0]     wgray, rgray;

  bmf_wr_ctl #(.DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_wr (
    .wclk_i     (wclk_i),
    .rst_ni     (rst_ni),
    .iw_sel_i   (iw_sel_i),
    .wen_ni     (wen_ni),
    .d_i        (d_i),
    .rgray_i    (rgray),
    .af_off_we_i(af_off_we_i),
    .af_off_i   (af_off_i),
    .mem_we_o   (mem_we),
    .mem_addr_o (waddr),
    .mem_wdata_o(wdata),
    .wgray_o    (wgray),
    .ff_n_o     (ff_n_o),
    .hf_n_o     (hf_n_o),
    .paf_n_o    (paf_n_o)
  );

  bmf_dpram #(.DEPTH(DEPTH), .W(WORD_W)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (mem_we),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr),
    .rdata_o(rdata)
  );

  bmf_rd_ctl #(.DEPTH(DEPTH), .DEF_OFF(DEF_OFF)) u_rd (
    .rclk_i     (rclk_i),
    .rst_ni     (rst_ni),
    .ow_sel_i   (ow_sel_i),
    .ren_ni     (ren_ni),
    .wgray_i    (wgray),
    .mem_rdata_i(rdata),
    .ae_off_we_i(ae_off_we_i),
    .ae_off_i   (ae_off_i),
    .mem_addr_o (raddr),
    .rgray_o    (rgray),
    .q_o        (q_o),
    .ef_n_o     (ef_n_o),
    .pae_n_o    (pae_n_o)
  );
endmodule

// File: rtl/bmf_fifo_chk.sv
module bmf_fifo_chk (
  input logic        wclk_i,
  input logic        rclk_i,
  input logic        rst_ni,
  input logic        ren_ni,
  input logic [17:0] q_o,
  input logic        ff_n_o,
  input logic        ef_n_o,
  input logic        hf_n_o,
  input logic        paf_n_o,
  input logic        pae_n_o
);
  // R7
  empty_read_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !ef_n_o |=> $stable(q_o));

  // R7
  idle_read_hold_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    ren_ni |=> $stable(q_o));

  // R9
  full_is_half_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !ff_n_o |-> !hf_n_o);

  // R10
  full_is_almost_full_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !ff_n_o |-> !paf_n_o);

  // R11
  empty_is_almost_empty_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !ef_n_o |-> !pae_n_o);
endmodule

bind bmf_fifo bmf_fifo_chk u_chk (
  .wclk_i (wclk_i),
  .rclk_i (rclk_i),
  .rst_ni (rst_ni),
  .ren_ni (ren_ni),
  .q_o    (q_o),
  .ff_n_o (ff_n_o),
  .ef_n_o (ef_n_o),
  .hf_n_o (hf_n_o),
  .paf_n_o(paf_n_o),
  .pae_n_o(pae_n_o)
);

// File: tb/bmf_fifo_test.sv
module bmf_fifo_test;
  localparam int CLK_PERIOD  = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 64;
  localparam int AW          = 6;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  logic iw_sel = 1'b0, ow_sel = 1'b0, wen_n = 1'b1, ren_n = 1'b1;
  logic [17:0] d = '0;
  logic [17:0] q;
  logic ff_n, ef_n, hf_n, paf_n, pae_n;
  logic af_we = 1'b0, ae_we = 1'b0;
  logic [AW-1:0] af_off = '0, ae_off = '0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  bmf_fifo #(.DEPTH(DEPTH)) uut (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .iw_sel_i(iw_sel), .ow_sel_i(ow_sel),
    .wen_ni(wen_n), .d_i(d), .ren_ni(ren_n), .q_o(q),
    .ff_n_o(ff_n), .ef_n_o(ef_n), .hf_n_o(hf_n), .paf_n_o(paf_n), .pae_n_o(pae_n),
    .af_off_we_i(af_we), .af_off_i(af_off), .ae_off_we_i(ae_we), .ae_off_i(ae_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic iw, input logic ow);
    rst_n = 1'b0; iw_sel = iw; ow_sel = ow; wen_n = 1'b1; ren_n = 1'b1;
    repeat (3) @(negedge rclk);
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    repeat (2) @(negedge wclk);
  endtask

  task automatic push(input logic [17:0] v);
    @(negedge wclk); wen_n = 1'b0; d = v;
    @(negedge wclk); wen_n = 1'b1;
  endtask

  task automatic pop(output logic [17:0] v);
    @(negedge rclk); ren_n = 1'b0;
    @(negedge rclk); ren_n = 1'b1; v = q;
  endtask

  task automatic settle();
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
  endtask

  task automatic set_ae(input logic [AW-1:0] v);
    @(negedge rclk); ae_we = 1'b1; ae_off = v;
    @(negedge rclk); ae_we = 1'b0;
  endtask

  task automatic set_af(input logic [AW-1:0] v);
    @(negedge wclk); af_we = 1'b1; af_off = v;
    @(negedge wclk); af_we = 1'b0;
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0);
    chk("R4 ff_n", ff_n, 1); chk("R4 ef_n", ef_n, 0); chk("R4 hf_n", hf_n, 1);
    chk("R4 paf_n", paf_n, 1); chk("R4 pae_n", pae_n, 0); chk("R3 q zero", q, 0);
  endtask

  task automatic t_basic();
    logic [17:0] v;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) push(18'h15555 ^ 18'(i * 18'h01111));
    settle();
    chk("R8 ef_n after writes", ef_n, 1);
    for (int i = 0; i < 5; i++) begin
      pop(v);
      chk("R7 order", v, 18'h15555 ^ 18'(i * 18'h01111));
    end
    settle();
    chk("R8 ef_n drained", ef_n, 0);
    pop(v);
    chk("R7 empty read holds q", v, 18'h15555 ^ 18'(4 * 18'h01111));
  endtask

  task automatic t_fill();
    logic [17:0] v;
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < DEPTH; i++) begin
      push(18'(i * 3 + 5));
      if (i + 1 == 7)  begin settle(); chk("R11 pae at 7", pae_n, 0); end
      if (i + 1 == 8)  begin settle(); chk("R11 pae at 8", pae_n, 1); end
      if (i + 1 == 32) chk("R9 hf at 32", hf_n, 1);
      if (i + 1 == 33) chk("R9 hf at 33", hf_n, 0);
      if (i + 1 == 56) chk("R10 paf at 56", paf_n, 1);
      if (i + 1 == 57) chk("R10 paf at 57", paf_n, 0);
      if (i + 1 == 63) chk("R5 ff_n at 63", ff_n, 1);
    end
    chk("R5 ff_n full", ff_n, 0);
    push(18'h3FFFF);
    pop(v);
    chk("R7 first of full", v, 18'd5);
    settle();
    chk("R6 ff_n after read", ff_n, 1);
    for (int i = 1; i < DEPTH; i++) begin
      pop(v);
      chk("R5 R7 fill order", v, 18'(i * 3 + 5));
    end
    settle();
    chk("R5 write when full ignored", ef_n, 0);
  endtask

  task automatic t_offsets();
    do_reset(1'b0, 1'b0);
    set_ae(6'd3);
    set_af(6'd2);
    for (int i = 0; i < 3; i++) push(18'(i));
    settle();
    chk("R12 ae offset 3 at 3", pae_n, 0);
    push(18'd3);
    settle();
    chk("R12 ae offset 3 at 4", pae_n, 1);
    for (int i = 4; i < 61; i++) push(18'(i));
    chk("R12 af offset 2 at 61", paf_n, 1);
    push(18'd61);
    chk("R12 af offset 2 at 62", paf_n, 0);
    do_reset(1'b0, 1'b0);
    for (int i = 0; i < 4; i++) push(18'(i));
    settle();
    chk("R3 ae offset default", pae_n, 0);
    chk("R3 af offset default", paf_n, 1);
  endtask

  task automatic t_pack();
    logic [17:0] v;
    do_reset(1'b1, 1'b0);
    push(18'h3FFA5);
    settle();
    chk("R1 lone half hidden", ef_n, 0);
    push(18'h0005A);
    settle();
    chk("R1 pair visible", ef_n, 1);
    pop(v);
    chk("R1 packed word", v, 18'h0B5A5);
  endtask

  task automatic t_unpack();
    logic [17:0] v;
    do_reset(1'b0, 1'b1);
    push(18'h2B3C4);
    settle();
    pop(v);
    chk("R2 low half first", v, 18'h001C4);
    chk("R8 pending half not empty", ef_n, 1);
    pop(v);
    chk("R2 high half second", v, 18'h00159);
    chk("R8 empty after halves", ef_n, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_basic();
    t_fill();
    t_offsets();
    t_pack();
    t_unpack();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule